// File: doc/BRIEF.md
# Receive-FIFO Error Tally and Sticky Status Register

This block is the 16-bit status word of a serial receiver/transmitter pair that has a 16-entry receive FIFO. Each FIFO entry carries two error tags along with its data byte: one for parity and one for framing. The block watches the FIFO's push and pop strobes and keeps a running tally of how many stored entries carry each tag. It also shows the tags of the entry currently at the FIFO head.

The low byte holds six sticky event flags. The transmitter and receiver raise them with single-cycle pulses. Software can clear a flag only after it has read that flag as 1: it reads the word, then writes 0 to the flag's bit position. Writing 1 never sets a flag. Writes never touch the tally fields or the head-tag bits.

The read data is combinational from internal state and the head-tag inputs, so it is valid in the same cycle as the read strobe.

Top module: `uart_stat_reg`

## Requirements
- R1: After synchronous reset the read word is 0x0060: bits 6 and 5 are 1 and every other bit is 0.
- R2: Bits 15:12 equal the number of FIFO entries tagged with a parity error. A push with the tag adds one. A pop while the head carries the tag subtracts one. A cycle with both applies the net change.
- R3: Bits 11:8 equal the number of FIFO entries tagged with a framing error, with the same push, pop and net-change rules as R2.
- R4: When all 16 stored entries carry a tag, that 4-bit field reads 0. After one tagged entry is popped, the field reads 15.
- R5: CPU writes of any value leave bits 15:8 and bits 3:2 unchanged.
- R6: Bit 3 shows the framing tag and bit 2 shows the parity tag of the head entry. Both read 0 while the FIFO is empty, even if the head-tag inputs are high.
- R7: Writing 1 to a flag position never sets a cleared flag and never clears a set flag.
- R8: A write of 0 clears a flag only if a read in an earlier cycle returned that flag as 1. A write of 0 in the same cycle as that first read leaves the flag set. Other flag bits written as 1 are unaffected.
- R9: If a hardware set pulse and a valid clearing write reach the same flag in the same cycle, the flag stays 1.
- R10: Once a flag has cleared, it must be read as 1 again before a 0 write can clear it again.
- R11: The event pulses map to fixed bits: rx_error to bit 7, tx_end to bit 6, tx_empty to bit 5, brk to bit 4, rx_full to bit 1, rx_ready to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Read strobe; arms the clear permission of flags that read as 1 |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Status word |
| fifo_push | input | 1 | Receive FIFO push strobe |
| push_perr | input | 1 | Parity tag of the pushed entry |
| push_ferr | input | 1 | Framing tag of the pushed entry |
| fifo_pop | input | 1 | Receive FIFO pop strobe |
| head_perr | input | 1 | Parity tag of the head entry |
| head_ferr | input | 1 | Framing tag of the head entry |
| fifo_empty | input | 1 | Receive FIFO holds no entries |
| ev_rx_error | input | 1 | Receive error event pulse |
| ev_tx_end | input | 1 | Transmission finished event pulse |
| ev_tx_empty | input | 1 | Transmit FIFO empty event pulse |
| ev_brk | input | 1 | Break detected event pulse |
| ev_rx_full | input | 1 | Receive FIFO full event pulse |
| ev_rx_ready | input | 1 | Receive data ready event pulse |

## Verification
The tallies are exercised in three phases. A fill of all 16 entries uses tag patterns that differ between parity and framing, which exposes swapped fields or counters that only increment. A run of simultaneous push and pop cycles over every combination of push tag and head tag exercises the net-change arithmetic, and a full drain follows it. A fill with every entry tagged checks the wrap to zero at 16.

The flags are exercised with three kinds of write. Writes of 0 with and without a prior read, including one in the same cycle as the read, show whether the clear permission is armed at the right time. Masked writes show that the clear acts only on the bit written as 0. Set pulses that coincide with clears, and writes after a flag has cleared and been set again, tell set-priority and re-arming faults apart.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int SHOW_W     = $clog2(FIFO_DEPTH);
    localparam int TALLY_W    = SHOW_W + 1;
    localparam int NUM_FLAGS  = 6;
    localparam int NUM_KINDS  = 2;

    // flag index k -> status bit position
    // k: 0 rx_ready, 1 rx_full, 2 brk, 3 tx_empty, 4 tx_end, 5 rx_error
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 6'b011000;

    typedef struct packed {
        logic ferr;
        logic perr;
    } err_tag_t;

    typedef struct packed {
        logic [SHOW_W-1:0] par_cnt;
        logic [SHOW_W-1:0] frm_cnt;
        logic [3:0]        flags_hi;
        logic              head_ferr;
        logic              head_perr;
        logic [1:0]        flags_lo;
    } stat_word_t;

    function automatic int flag_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            default: return 7;
        endcase
    endfunction

    function automatic logic tag_sel(input err_tag_t t, input int kind);
        return (kind == 0) ? t.perr : t.ferr;
    endfunction

endpackage

// File: rtl/err_tally.sv
module err_tally #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          push_tag,
    input  logic          pop,
    input  logic          pop_tag,
    output logic [CW-1:0] count
);
    logic          inc, dec;
    logic [CW-1:0] nxt;

    assign inc = push && push_tag;
    assign dec = pop && pop_tag;

    always_comb begin
        nxt = count;
        if (inc && !dec)      nxt = count + CW'(1);
        else if (dec && !inc) nxt = count - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    // R2/R3: tally never exceeds the FIFO depth
    assert_tally_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3: no FIFO traffic means the tally holds
    assert_tally_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(count));

    // R2: a lone tagged push raises the tally by one
    assert_tally_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (push && push_tag && !pop) |=> (count == $past(count) + CW'(1)));

endmodule

// File: rtl/status_flag.sv
module status_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic rd,
    input  logic wr,
    input  logic wr_bit,
    output logic flag
);
    logic seen;
    logic clr_ok;
    logic flag_nxt;

    assign clr_ok = wr && !wr_bit && seen;

    always_comb begin
        if (set)         flag_nxt = 1'b1;
        else if (clr_ok) flag_nxt = 1'b0;
        else             flag_nxt = flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= RST_VAL;
            seen <= 1'b0;
        end else begin
            flag <= flag_nxt;
            if (!flag_nxt)       seen <= 1'b0;
            else if (rd && flag) seen <= 1'b1;
        end
    end

    // R7: a flag goes from 0 to 1 only through a set pulse
    assert_rise_by_event_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set));

    // R8: a flag falls only after an armed zero write without a set pulse
    assert_fall_needs_read_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(seen && wr && !wr_bit && !set));

    // R9: a set pulse always leaves the flag high
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R10: the permission latch is never held while the flag is low
    assert_seen_drops_R10: assert property (@(posedge clk) disable iff (rst)
        !flag |-> !seen);

endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
    import uart_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    input  logic        fifo_push,
    input  logic        push_perr,
    input  logic        push_ferr,
    input  logic        fifo_pop,
    input  logic        head_perr,
    input  logic        head_ferr,
    input  logic        fifo_empty,
    input  logic        ev_rx_error,
    input  logic        ev_tx_end,
    input  logic        ev_tx_empty,
    input  logic        ev_brk,
    input  logic        ev_rx_full,
    input  logic        ev_rx_ready
);
    err_tag_t               push_tag, head_tag;
    logic [TALLY_W-1:0]     tally [NUM_KINDS];
    logic [NUM_FLAGS-1:0]   ev_vec, flag_vec;
    stat_word_t             word;
    logic                   unused_wbits;

    assign push_tag = '{ferr: push_ferr, perr: push_perr};
    assign head_tag = '{ferr: head_ferr, perr: head_perr};
    assign ev_vec   = {ev_rx_error, ev_tx_end, ev_tx_empty,
                       ev_brk, ev_rx_full, ev_rx_ready};
    assign unused_wbits = ^{cpu_wdata[15:8], cpu_wdata[3:2]};

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_tally
            err_tally #(.DEPTH(FIFO_DEPTH)) u_tally (
                .clk      (clk),
                .rst      (rst),
                .push     (fifo_push),
                .push_tag (tag_sel(push_tag, k)),
                .pop      (fifo_pop),
                .pop_tag  (tag_sel(head_tag, k)),
                .count    (tally[k])
            );
        end

        for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
            status_flag #(.RST_VAL(FLAG_RST[f])) u_flag (
                .clk    (clk),
                .rst    (rst),
                .set    (ev_vec[f]),
                .rd     (cpu_rd),
                .wr     (cpu_wr),
                .wr_bit (cpu_wdata[flag_pos(f)]),
                .flag   (flag_vec[f])
            );
        end
    endgenerate

    always_comb begin
        word.par_cnt   = tally[0][SHOW_W-1:0];
        word.frm_cnt   = tally[1][SHOW_W-1:0];
        word.flags_hi  = flag_vec[5:2];
        word.head_ferr = head_tag.ferr && !fifo_empty;
        word.head_perr = head_tag.perr && !fifo_empty;
        word.flags_lo  = flag_vec[1:0];
    end

    assign cpu_rdata = word;

    // R5: the tally byte moves only with FIFO traffic, never with writes
    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!fifo_push && !fifo_pop) |=> $stable(cpu_rdata[15:8]));

    // R6: head tag bits are dark while the FIFO is empty
    assert_empty_dark_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> (cpu_rdata[3:2] == 2'b00));

endmodule

// File: tb/uart_stat_reg_tb.sv
module uart_stat_reg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_rd = 0, cpu_wr = 0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        fifo_push = 0, push_perr = 0, push_ferr = 0, fifo_pop = 0;
    logic        head_perr = 0, head_ferr = 0, fifo_empty = 1;
    logic [5:0]  ev = '0;

    int n_vec = 0, n_bad = 0;
    bit qp[$];
    bit qf[$];
    logic [7:0] eflags = 8'h60;

    always #10 clk = ~clk;

    uart_stat_reg u_dut (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .fifo_push(fifo_push), .push_perr(push_perr), .push_ferr(push_ferr),
        .fifo_pop(fifo_pop), .head_perr(head_perr), .head_ferr(head_ferr),
        .fifo_empty(fifo_empty),
        .ev_rx_error(ev[5]), .ev_tx_end(ev[4]), .ev_tx_empty(ev[3]),
        .ev_brk(ev[2]), .ev_rx_full(ev[1]), .ev_rx_ready(ev[0])
    );

    function automatic logic [15:0] exp_word();
        int pc = 0, fc = 0;
        logic hp, hf;
        foreach (qp[i]) pc += int'(qp[i]);
        foreach (qf[i]) fc += int'(qf[i]);
        hp = (qp.size() > 0) ? qp[0] : 1'b0;
        hf = (qf.size() > 0) ? qf[0] : 1'b0;
        return {4'(pc % 16), 4'(fc % 16), eflags | {4'b0, hf, hp, 2'b0}};
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        n_vec++;
        if (cpu_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, cpu_rdata, exp);
        end
    endtask

    task automatic cyc(input bit psh, input bit pp, input bit pf, input bit pop,
                       input bit rd, input bit wr, input logic [15:0] wd,
                       input logic [5:0] evs);
        fifo_push = psh; push_perr = pp; push_ferr = pf; fifo_pop = pop;
        cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd; ev = evs;
        @(posedge clk); #1;
        if (pop) begin void'(qp.pop_front()); void'(qf.pop_front()); end
        if (psh) begin qp.push_back(pp); qf.push_back(pf); end
        fifo_push = 0; fifo_pop = 0; cpu_rd = 0; cpu_wr = 0; ev = '0;
        head_perr  = (qp.size() > 0) ? qp[0] : 1'b0;
        head_ferr  = (qf.size() > 0) ? qf[0] : 1'b0;
        fifo_empty = (qp.size() == 0);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0; #1;
        check("R1 reset word", 16'h0060);

        // R2 R3: fill with distinct parity/framing patterns
        for (int i = 0; i < 16; i++) begin
            cyc(1, i[0] ^ i[2], i[1], 0, 0, 0, 16'h0, 6'h0);
            check("R2/R3 fill", exp_word());
        end
        // R2 R3: simultaneous push and pop over every tag mix
        for (int j = 0; j < 32; j++) begin
            cyc(1, j[0], j[1] ^ j[3], 1, 0, 0, 16'h0, 6'h0);
            check("R2/R3 push+pop", exp_word());
        end
        // drain to empty, R6 at the end
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 1, 0, 0, 16'h0, 6'h0);
            check("R2/R3/R6 drain", exp_word());
        end
        // R6: head inputs high while empty must read dark
        head_perr = 1; head_ferr = 1; #1;
        check("R6 empty gating", 16'h0060);
        head_perr = 0; head_ferr = 0;

        // R4: all 16 tagged wraps to 0, one pop gives 15
        for (int i = 0; i < 16; i++) cyc(1, 1, 1, 0, 0, 0, 16'h0, 6'h0);
        check("R4 full wrap", 16'h006C);
        cyc(0, 0, 0, 1, 0, 0, 16'h0, 6'h0);
        check("R4 after pop", 16'hFF6C);
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0, 0, 16'h0, 6'h0);
        check("R2 partial drain", exp_word());

        // R5 R7: writes change nothing without a prior read
        cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
        check("R5 write zeros", exp_word());
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFF, 6'h0);
        check("R5/R7 write ones", exp_word());

        // R11: each event reaches its own bit
        for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'(1 << k));
            case (k)
                0: eflags[0] = 1; 1: eflags[1] = 1; 2: eflags[4] = 1;
                3: eflags[5] = 1; 4: eflags[6] = 1; default: eflags[7] = 1;
            endcase
            check("R11 event map", exp_word());
        end
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFF, 6'h0);
        check("R7 write one keeps flags", exp_word());

        // R8: zero write needs a prior read; only bit 7 cleared
        cyc(0, 0, 0, 0, 0, 1, 16'hFF7F, 6'h0);
        check("R8 unread zero write", exp_word());
        cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
        cyc(0, 0, 0, 0, 0, 1, 16'hFF7F, 6'h0);
        eflags[7] = 0;
        check("R8 armed clear", exp_word());
        // R8: same-cycle read and write does not clear
        cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'b100000);
        eflags[7] = 1;
        cyc(0, 0, 0, 0, 1, 1, 16'hFF7F, 6'h0);
        check("R8 same-cycle read", exp_word());
        cyc(0, 0, 0, 0, 0, 1, 16'hFF7F, 6'h0);
        eflags[7] = 0;
        check("R8 next-cycle clear", exp_word());

        // R9: set wins over an armed clear
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFE, 6'b000001);
        check("R9 set wins", exp_word());
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFE, 6'h0);
        eflags[0] = 0;
        check("R9 clear after", exp_word());

        // R10: re-set flag needs a fresh read
        cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'b000001);
        eflags[0] = 1;
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFE, 6'h0);
        check("R10 not re-armed", exp_word());
        cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFE, 6'h0);
        eflags[0] = 0;
        check("R10 re-armed clear", exp_word());

        // R8: full zero write clears every armed flag
        cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
        eflags = 8'h00;
        check("R8 clear all armed", exp_word());

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule